// File: doc/BRIEF.md
# Iterative Integer Multiplier with Accumulate

This block multiplies two 32-bit operands for a processor datapath. It consumes the multiplier operand eight bits per clock. It offers four operations. The short multiply keeps the low word of the product. The short multiply-accumulate adds a 32-bit value to that low word. The long multiply produces the full 64-bit product. The long multiply-accumulate adds a 64-bit value to that product. Either long form can treat its operands as signed or as unsigned. A signed long product is built from operand magnitudes, and the block negates it at the end when the operand signs differ.

The datapath puts a request on the input pins together with `in_valid`. The block accepts the request on a clock edge where `in_valid` and `in_ready` are both high. The operand pins only need to hold their values on that edge. `in_ready` stays low from the accepting edge until the edge that publishes the result, and `in_valid` has no effect while `in_ready` is low. The result side has no back-pressure. `done` pulses for one cycle, and the result, the flags and the cycle count then hold their values until the next `done`.

The block returns new negative and zero flags when asked to. It passes the carry and overflow flags through unchanged. It also reports the cycle cost of the operation, computed from the operation type and the size of the multiplier.

Top module: `iter_mul`

## Requirements
- R1: A short multiply (`op_long`=0, `op_acc`=0) returns the low 32 bits of `mcand*mplier` on `res_lo`, and `res_hi` is 0.
- R2: A short multiply-accumulate (`op_long`=0, `op_acc`=1) returns `mcand*mplier + acc_lo` modulo 2^32 on `res_lo`, and `res_hi` is 0.
- R3: An unsigned long multiply (`op_long`=1, `op_signed`=0) returns the 64-bit product of the zero-extended operands, with bits 63:32 on `res_hi` and bits 31:0 on `res_lo`.
- R4: A signed long multiply (`op_signed`=1) treats both operands as two's complement and returns the exact 64-bit product. 0x80000000 times 0x80000000 gives 0x4000000000000000.
- R5: A long multiply-accumulate adds `{acc_hi,acc_lo}` to the 64-bit product, and any carry out of the low word reaches the high word.
- R6: When `set_flags`=1, a short form sets `flag_n` to bit 31 of the result and sets `flag_z` when the 32-bit result is zero. A long form sets `flag_n` to bit 63 and sets `flag_z` only when all 64 bits are zero. When `set_flags`=0, `flag_n` and `flag_z` keep their previous values.
- R7: `flag_c` and `flag_v` return the `flag_c_in` and `flag_v_in` values sampled when the request was accepted.
- R8: `cycle_cnt` = base + A + M. The base is 1 for a short form and 2 for a long form. A is 1 for an accumulate form and 0 otherwise. M is 1 if `mplier` bits 31:8 are all zeros or all ones, 2 if bits 31:16 are, 3 if bits 31:24 are, and 4 otherwise.
- R9: `done` rises N+1 clock edges after the accepting edge and is high for exactly one cycle. N is the index (1 to 4) of the highest nonzero byte of the multiplier magnitude, and N is 1 for a zero magnitude. The magnitude is |`mplier`| for a signed long form and `mplier` otherwise.
- R10: `in_ready` is low from the accepting edge until `done`, and a request presented in that window is ignored. All outputs stay unchanged until the next `done`.
- R11: After reset, `in_ready`=1, `done`=0, and all result, flag and count outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to accept a request |
| op_long | input | 1 | 1 selects a 64-bit result |
| op_acc | input | 1 | 1 adds the accumulate value |
| op_signed | input | 1 | 1 selects signed operands for the long forms |
| set_flags | input | 1 | 1 updates the N and Z flags |
| mcand | input | 32 | Multiplicand |
| mplier | input | 32 | Multiplier; its size sets latency and reported cost |
| acc_lo | input | 32 | Accumulate low word (the only accumulate word for short forms) |
| acc_hi | input | 32 | Accumulate high word for the long forms |
| flag_c_in | input | 1 | Current carry flag |
| flag_v_in | input | 1 | Current overflow flag |
| done | output | 1 | One-cycle result strobe |
| res_lo | output | 32 | Result bits 31:0 |
| res_hi | output | 32 | Result bits 63:32 (0 for short forms) |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag, passed through |
| flag_v | output | 1 | Overflow flag, passed through |
| cycle_cnt | output | 3 | Reported cycle cost of the operation |

## Verification
The bench squares the most negative 32-bit value. A design that takes the magnitude with too few bits, or that skips the final negation, gets the sign or the high word of this product wrong. A long accumulate whose low-word sum overflows shows whether a design drops the carry into the high word. A product that is zero only in its low word shows whether a design computes the long-form Z flag from 32 bits instead of 64. A negative multiplier that is small in magnitude, and an unsigned multiplier with all its top bits set, pull the reported cost apart from the real latency. A design that mixes up those two counts fails the checks on `cycle_cnt` or on latency. The bench also drives a request while the block is busy and checks that the result belongs to the first request.

// File: rtl/iter_mul_pkg.sv
package iter_mul_pkg;

  typedef enum logic [1:0] {
    MS_IDLE,
    MS_RUN,
    MS_FIN
  } mstate_t;

  // Fixed part of the reported cost: long forms cost one more, accumulate one more.
  function automatic logic [1:0] base_cost(input logic is_long, input logic is_acc);
    base_cost = (is_long ? 2'd2 : 2'd1) + (is_acc ? 2'd1 : 2'd0);
  endfunction

endpackage

// File: rtl/iter_mul_prep.sv
module iter_mul_prep #(
  parameter int W  = 32,
  parameter int CH = 8,
  parameter int CW = 3
) (
  input  logic [W-1:0]  mcand,
  input  logic [W-1:0]  mplier,
  input  logic          sgn,
  output logic [W-1:0]  mc_mag,
  output logic [W-1:0]  mp_mag,
  output logic          neg,
  output logic [CW-1:0] m_extra,
  output logic [CW-1:0] n_chunks
);
  localparam int NCH = W / CH;

  always_comb begin
    mc_mag = (sgn && mcand[W-1])  ? (~mcand + W'(1))  : mcand;
    mp_mag = (sgn && mplier[W-1]) ? (~mplier + W'(1)) : mplier;
    neg    = sgn && (mcand[W-1] ^ mplier[W-1]);
  end

  // Chunks the iterative core must consume: up to the highest nonzero chunk.
  always_comb begin
    n_chunks = CW'(1);
    for (int i = 0; i < NCH; i++) begin
      if (|mp_mag[i*CH +: CH]) n_chunks = CW'(i + 1);
    end
  end

  // Reported extra cost: the smallest k for which the bits above k chunks are
  // all zeros or all ones in the raw multiplier.
  always_comb begin
    logic [W-1:0] upper;
    m_extra = CW'(NCH);
    for (int k = NCH - 1; k >= 1; k--) begin
      upper = mplier >> (k * CH);
      if (upper == '0 || upper == ({W{1'b1}} >> (k * CH))) m_extra = CW'(k);
    end
  end

endmodule

// File: rtl/iter_mul_core.sv
module iter_mul_core #(
  parameter int W  = 32,
  parameter int CH = 8,
  parameter int CW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic [W-1:0]    mc_mag,
  input  logic [W-1:0]    mp_mag,
  input  logic [CW-1:0]   n_chunks,
  output logic [2*W-1:0]  prod,
  output logic            last
);
  logic [2*W-1:0] sum_q, mc_q, partial;
  logic [W-1:0]   mp_q;
  logic [CW-1:0]  k_q, n_q;

  assign partial = mc_q * {{(2*W-CH){1'b0}}, mp_q[CH-1:0]};
  assign last    = (k_q == n_q - CW'(1));
  assign prod    = sum_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q <= '0;
      mc_q  <= '0;
      mp_q  <= '0;
      k_q   <= '0;
      n_q   <= CW'(1);
    end else if (load) begin
      sum_q <= '0;
      mc_q  <= {{W{1'b0}}, mc_mag};
      mp_q  <= mp_mag;
      k_q   <= '0;
      n_q   <= n_chunks;
    end else if (step) begin
      sum_q <= sum_q + partial;
      mc_q  <= mc_q << CH;
      mp_q  <= mp_q >> CH;
      k_q   <= k_q + CW'(1);
    end
  end

endmodule

// File: rtl/iter_mul_finish.sv
module iter_mul_finish #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] prod,
  input  logic           neg,
  input  logic           is_long,
  input  logic           is_acc,
  input  logic [W-1:0]   acc_lo,
  input  logic [W-1:0]   acc_hi,
  output logic [W-1:0]   r_lo,
  output logic [W-1:0]   r_hi,
  output logic           n_out,
  output logic           z_out
);
  logic [2*W-1:0] signed_prod, long_sum;
  logic [W-1:0]   short_sum;

  always_comb begin
    signed_prod = neg ? (~prod + (2*W)'(1)) : prod;
    long_sum    = signed_prod + (is_acc ? {acc_hi, acc_lo} : '0);
    short_sum   = signed_prod[W-1:0] + (is_acc ? acc_lo : '0);
    if (is_long) begin
      r_lo  = long_sum[W-1:0];
      r_hi  = long_sum[2*W-1:W];
      n_out = long_sum[2*W-1];
      z_out = (long_sum == '0);
    end else begin
      r_lo  = short_sum;
      r_hi  = '0;
      n_out = short_sum[W-1];
      z_out = (short_sum == '0);
    end
  end

endmodule

// File: rtl/iter_mul.sv
module iter_mul #(
  parameter int W     = 32,
  parameter int CH    = 8,
  parameter int CNT_W = $clog2(W / CH + 4)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             op_long,
  input  logic             op_acc,
  input  logic             op_signed,
  input  logic             set_flags,
  input  logic [W-1:0]     mcand,
  input  logic [W-1:0]     mplier,
  input  logic [W-1:0]     acc_lo,
  input  logic [W-1:0]     acc_hi,
  input  logic             flag_c_in,
  input  logic             flag_v_in,
  output logic             done,
  output logic [W-1:0]     res_lo,
  output logic [W-1:0]     res_hi,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v,
  output logic [CNT_W-1:0] cycle_cnt
);
  import iter_mul_pkg::*;

  localparam int NCH = W / CH;
  localparam int CW  = $clog2(NCH + 1);

  mstate_t        st_q;
  logic           accept, last;
  logic [W-1:0]   mc_mag, mp_mag, f_lo, f_hi;
  logic           neg, f_n, f_z;
  logic [CW-1:0]  m_extra, n_chunks;
  logic [2*W-1:0] prod;

  logic             long_q, acc_q, sf_q, neg_q, c_q, v_q;
  logic [W-1:0]     alo_q, ahi_q;
  logic [CNT_W-1:0] cnt_q;

  assign in_ready = (st_q == MS_IDLE);
  assign accept   = in_ready && in_valid;

  iter_mul_prep #(.W(W), .CH(CH), .CW(CW)) u_prep (
    .mcand    (mcand),
    .mplier   (mplier),
    .sgn      (op_signed && op_long),
    .mc_mag   (mc_mag),
    .mp_mag   (mp_mag),
    .neg      (neg),
    .m_extra  (m_extra),
    .n_chunks (n_chunks)
  );

  iter_mul_core #(.W(W), .CH(CH), .CW(CW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .step     (st_q == MS_RUN),
    .mc_mag   (mc_mag),
    .mp_mag   (mp_mag),
    .n_chunks (n_chunks),
    .prod     (prod),
    .last     (last)
  );

  iter_mul_finish #(.W(W)) u_fin (
    .prod    (prod),
    .neg     (neg_q),
    .is_long (long_q),
    .is_acc  (acc_q),
    .acc_lo  (alo_q),
    .acc_hi  (ahi_q),
    .r_lo    (f_lo),
    .r_hi    (f_hi),
    .n_out   (f_n),
    .z_out   (f_z)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= MS_IDLE;
      long_q <= 1'b0;
      acc_q  <= 1'b0;
      sf_q   <= 1'b0;
      neg_q  <= 1'b0;
      c_q    <= 1'b0;
      v_q    <= 1'b0;
      alo_q  <= '0;
      ahi_q  <= '0;
      cnt_q  <= '0;
    end else begin
      case (st_q)
        MS_IDLE: if (accept) begin
          st_q   <= MS_RUN;
          long_q <= op_long;
          acc_q  <= op_acc;
          sf_q   <= set_flags;
          neg_q  <= neg;
          c_q    <= flag_c_in;
          v_q    <= flag_v_in;
          alo_q  <= acc_lo;
          ahi_q  <= acc_hi;
          cnt_q  <= CNT_W'(base_cost(op_long, op_acc)) + CNT_W'(m_extra);
        end
        MS_RUN:  if (last) st_q <= MS_FIN;
        default: st_q <= MS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      res_lo    <= '0;
      res_hi    <= '0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_c    <= 1'b0;
      flag_v    <= 1'b0;
      cycle_cnt <= '0;
    end else begin
      done <= (st_q == MS_FIN);
      if (st_q == MS_FIN) begin
        res_lo    <= f_lo;
        res_hi    <= f_hi;
        flag_c    <= c_q;
        flag_v    <= v_q;
        cycle_cnt <= cnt_q;
        if (sf_q) begin
          flag_n <= f_n;
          flag_z <= f_z;
        end
      end
    end
  end

endmodule

// File: rtl/iter_mul_chk.sv
module iter_mul_chk #(
  parameter int W     = 32,
  parameter int CH    = 8,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             done,
  input logic [W-1:0]     res_lo,
  input logic [W-1:0]     res_hi,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_c,
  input logic             flag_v,
  input logic [CNT_W-1:0] cycle_cnt
);
  localparam int NCH = W / CH;

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r10_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  a_r10_outputs_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({res_hi, res_lo, flag_n, flag_z, flag_c, flag_v, cycle_cnt}));

  a_r8_cost_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycle_cnt >= CNT_W'(2)) && (cycle_cnt <= CNT_W'(NCH + 3)));

endmodule

bind iter_mul iter_mul_chk #(.W(W), .CH(CH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .done      (done),
  .res_lo    (res_lo),
  .res_hi    (res_hi),
  .flag_n    (flag_n),
  .flag_z    (flag_z),
  .flag_c    (flag_c),
  .flag_v    (flag_v),
  .cycle_cnt (cycle_cnt)
);

// File: tb/iter_mul_tb.sv
`timescale 1ns/1ps
module iter_mul_tb;

  typedef struct packed {
    logic        lng;
    logic        acc;
    logic        sgn;
    logic        setf;
    logic        c;
    logic        v;
    logic [31:0] mc;
    logic [31:0] mp;
    logic [31:0] alo;
    logic [31:0] ahi;
    logic [2:0]  cnt;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 12;
  // lng acc sgn setf c v | mcand mplier acc_lo acc_hi | cost latency
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 32'h00000007, 32'h00000006, 32'h0,        32'h0, 3'd2, 4'd2},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1, 32'hFFFFFFFF, 32'h00001234, 32'h00000005, 32'h0, 3'd4, 4'd3},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,        32'h0, 3'd3, 4'd5},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 32'h80000000, 32'h80000000, 32'h0,        32'h0, 3'd6, 4'd5},
    '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0, 32'hFFFFFFFD, 32'h00000005, 32'h0,        32'h0, 3'd3, 4'd2},
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 32'h00010000, 32'hFFFFFF00, 32'h01000000, 32'h0, 3'd4, 4'd3},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 32'h0, 3'd4, 4'd2},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 32'h00010000, 32'h00010000, 32'h0,        32'h0, 3'd4, 4'd4},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1, 32'h00000002, 32'hFFFFFFFF, 32'h0,        32'h0, 3'd3, 4'd2},
    '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h0,        32'h0, 3'd6, 4'd5},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 32'h00000003, 32'h01000000, 32'h0,        32'h0, 3'd5, 4'd5},
    '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1, 32'h00000001, 32'hFF800000, 32'h0,        32'h0, 3'd5, 4'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, op_long = 1'b0, op_acc = 1'b0, op_signed = 1'b0, set_flags = 1'b0;
  logic [31:0] mcand = '0, mplier = '0, acc_lo = '0, acc_hi = '0;
  logic        flag_c_in = 1'b0, flag_v_in = 1'b0;
  logic        in_ready, done, flag_n, flag_z, flag_c, flag_v;
  logic [31:0] res_lo, res_hi;
  logic [2:0]  cycle_cnt;

  int nchk = 0;
  int nfail = 0;
  logic exp_n = 1'b0, exp_z = 1'b0;

  always #4 clk = ~clk;

  iter_mul u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_long(op_long), .op_acc(op_acc), .op_signed(op_signed), .set_flags(set_flags),
    .mcand(mcand), .mplier(mplier), .acc_lo(acc_lo), .acc_hi(acc_hi),
    .flag_c_in(flag_c_in), .flag_v_in(flag_v_in), .done(done),
    .res_lo(res_lo), .res_hi(res_hi), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v), .cycle_cnt(cycle_cnt)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_result(input vec_t t);
    logic [63:0] a, b, p;
    logic [31:0] s;
    if (t.lng) begin
      a = t.sgn ? {{32{t.mc[31]}}, t.mc} : {32'h0, t.mc};
      b = t.sgn ? {{32{t.mp[31]}}, t.mp} : {32'h0, t.mp};
      p = a * b;
      if (t.acc) p = p + {t.ahi, t.alo};
    end else begin
      s = t.mc * t.mp;
      if (t.acc) s = s + t.alo;
      p = {32'h0, s};
    end
    return p;
  endfunction

  task automatic run_vec(input vec_t t, input logic intrude);
    logic [63:0] exp;
    string rt;
    int lat;
    exp = ref_result(t);
    rt = t.lng ? (t.acc ? "R5" : (t.sgn ? "R4" : "R3")) : (t.acc ? "R2" : "R1");
    if (t.setf) begin
      exp_n = t.lng ? exp[63] : exp[31];
      exp_z = t.lng ? (exp == 64'h0) : (exp[31:0] == 32'h0);
    end
    @(negedge clk);
    in_valid = 1'b1; op_long = t.lng; op_acc = t.acc; op_signed = t.sgn; set_flags = t.setf;
    mcand = t.mc; mplier = t.mp; acc_lo = t.alo; acc_hi = t.ahi;
    flag_c_in = t.c; flag_v_in = t.v;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (intrude) begin
      check("R10", "in_ready while busy", {63'h0, in_ready}, 64'h0);
      in_valid = 1'b1; op_long = 1'b0; op_acc = 1'b0; mcand = 32'h1; mplier = 32'h1;
      flag_c_in = ~t.c; flag_v_in = ~t.v;
    end
    lat = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      in_valid = 1'b0;
      if (done) break;
    end
    check("R9", "latency", 64'(lat), 64'(t.lat));
    check(rt, "res_lo", {32'h0, res_lo}, {32'h0, exp[31:0]});
    check(rt, "res_hi", {32'h0, res_hi}, {32'h0, exp[63:32]});
    check("R6", "flag_n", {63'h0, flag_n}, {63'h0, exp_n});
    check("R6", "flag_z", {63'h0, flag_z}, {63'h0, exp_z});
    check("R7", "flag_c/v", {62'h0, flag_c, flag_v}, {62'h0, t.c, t.v});
    check("R8", "cycle_cnt", {61'h0, cycle_cnt}, {61'h0, t.cnt});
    @(negedge clk);
    check("R9", "done one cycle", {63'h0, done}, 64'h0);
    if (intrude) begin
      repeat (4) @(negedge clk);
      check("R10", "held res_lo", {32'h0, res_lo}, {32'h0, exp[31:0]});
      check("R10", "held flags", {60'h0, flag_n, flag_z, flag_c, flag_v},
            {60'h0, exp_n, exp_z, t.c, t.v});
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    check("R11", "in_ready", {63'h0, in_ready}, 64'h1);
    check("R11", "done", {63'h0, done}, 64'h0);
    check("R11", "results", {res_hi, res_lo}, 64'h0);
    check("R11", "flags/cnt", {57'h0, flag_n, flag_z, flag_c, flag_v, cycle_cnt}, 64'h0);
    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);
    // R10: request during busy is ignored, then outputs held
    run_vec(VECS[9], 1'b1);
    // R4: most negative value squared, repeated after the busy test
    run_vec(VECS[3], 1'b0);
    finish_run();
  end

endmodule